// File: doc/BRIEF.md
# Serial Divider Configuration Receiver

This block receives divider settings for a clock synthesizer over a three-wire serial port made of a serial clock, a data line and a load strobe. Each rising edge of the serial clock pushes one data bit into an 18-bit shift register. The load strobe then moves that word into a holding latch. The latch drives three divider values: a 5-bit pre-scale, a 3-bit output divider and a 10-bit feedback divider.

The serial pins are asynchronous to the block clock. All three pass through flop synchronizers, and their edges are found on the synchronized copies, so the serial clock and the load strobe never clock any flop. While the strobe is high the latch tracks the shift register. When the strobe falls the latch freezes, and a one-cycle update pulse tells downstream logic that new divider values are in force. Later shifting does not reach the outputs until the next load.

Top module: `cfg_serial_rx`

## Requirements
- R1: While rst_ni is low, the outputs pre_div_o, post_div_o, fb_div_o, update_o and the internal shift register are all zero.
- R2: The shift register moves by exactly one bit for each rising edge of sclk_i and takes in the level sdata_i had at that edge. A falling edge of sclk_i does not shift.
- R3: The first bit shifted in is the pre-scale MSB. The pre-scale field is word bits 17:13, sent MSB first. The output divider follows in bits 12:10, then the feedback divider in bits 9:0, and the feedback LSB is the last bit sent.
- R4: Only the 18 most recent bits are kept. If more than 18 bits are sent, the earliest ones are lost. If fewer are sent, older bits move up to fill the word.
- R5: A rising edge of sload_i copies the shift register into the divider outputs.
- R6: While sload_i stays high, the divider outputs follow the shift register, including bits shifted in during that time.
- R7: After sload_i falls, the divider outputs hold their value regardless of sclk_i and sdata_i until sload_i rises again.
- R8: Each falling edge of sload_i produces exactly one update_o pulse, one clock cycle wide. update_o stays low at all other times.
- R9: A change on sdata_i with no rising edge on sclk_i leaves the shift register unchanged.
- R10: With the default of two synchronizer stages, the following all happen on the third rising clk_i edge after a pin edge: a shift after an sclk_i rise, a transfer after an sload_i rise, and the update_o pulse after an sload_i fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock pin, asynchronous |
| sdata_i | input | 1 | Serial data pin, asynchronous |
| sload_i | input | 1 | Load strobe pin, asynchronous |
| pre_div_o | output | 5 | Latched pre-scale value |
| post_div_o | output | 3 | Latched output divider value |
| fb_div_o | output | 10 | Latched feedback divider value |
| update_o | output | 1 | One-cycle pulse when new values take effect |

## Verification
The bound checker looks at every cycle. It checks that each detected serial-clock rise advances the shift register by exactly the synchronized data bit, and that no other cycle changes it. It checks that the outputs copy the shift register while the synchronized strobe is high and stay frozen while it is low. It also checks that each update pulse is one cycle wide and directly follows a strobe fall. Only the bench scenarios can show the rest: the field order of a full word, the result of short and overlong bit streams, that data glitches are ignored at the pins, and the exact pin-to-output latency. The bench covers these with a pin-level reference model that it compares against the outputs on every cycle.

// File: rtl/cfg_rx_pkg.sv
package cfg_rx_pkg;
  localparam int unsigned PRE_W  = 5;
  localparam int unsigned POST_W = 3;
  localparam int unsigned FB_W   = 10;
  localparam int unsigned WORD_W = PRE_W + POST_W + FB_W;

  // packing order equals serial arrival order, MSB first
  typedef struct packed {
    logic [PRE_W-1:0]  pre;
    logic [POST_W-1:0] post;
    logic [FB_W-1:0]   fb;
  } div_cfg_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= async_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cfg_edge.sv
module cfg_edge #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  assign prev_o = prev_q;
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int unsigned WIDTH = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] word_o
);
  logic [WIDTH-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '0;
    else if (step_i) word_q <= {word_q[WIDTH-2:0], bit_i};
  end

  assign word_o = word_q;
endmodule

// File: rtl/cfg_hold.sv
module cfg_hold
  import cfg_rx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     follow_i,
  input  logic     commit_i,
  input  div_cfg_t word_i,
  output div_cfg_t word_o,
  output logic     update_o
);
  div_cfg_t word_q;
  logic     update_q;

  // transparent while strobe high, frozen otherwise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       word_q <= '0;
    else if (follow_i) word_q <= word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) update_q <= 1'b0;
    else         update_q <= commit_i;
  end

  assign word_o   = word_q;
  assign update_o = update_q;
endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx
  import cfg_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              sload_i,
  output logic [PRE_W-1:0]  pre_div_o,
  output logic [POST_W-1:0] post_div_o,
  output logic [FB_W-1:0]   fb_div_o,
  output logic              update_o
);
  localparam int unsigned PIN_W = 3;

  logic [PIN_W-1:0]  pins_s;
  logic [1:0]        ctrl_prev;
  logic              sclk_s, sdata_s, sload_s;
  logic              sclk_rise, sload_fall;
  logic [WORD_W-1:0] shift_w;
  div_cfg_t          cfg_w;

  cfg_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({sload_i, sdata_i, sclk_i}),
    .sync_o  (pins_s)
  );

  assign sclk_s  = pins_s[0];
  assign sdata_s = pins_s[1];
  assign sload_s = pins_s[2];

  cfg_edge #(.WIDTH(2)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  ({sload_s, sclk_s}),
    .prev_o (ctrl_prev)
  );

  assign sclk_rise  = sclk_s & ~ctrl_prev[0];
  assign sload_fall = ~sload_s & ctrl_prev[1];

  cfg_shift #(.WIDTH(WORD_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (sclk_rise),
    .bit_i  (sdata_s),
    .word_o (shift_w)
  );

  cfg_hold u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .follow_i (sload_s),
    .commit_i (sload_fall),
    .word_i   (div_cfg_t'(shift_w)),
    .word_o   (cfg_w),
    .update_o (update_o)
  );

  assign pre_div_o  = cfg_w.pre;
  assign post_div_o = cfg_w.post;
  assign fb_div_o   = cfg_w.fb;
endmodule

// File: rtl/cfg_serial_rx_chk.sv
module cfg_serial_rx_chk
  import cfg_rx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sload_s,
  input logic              sdata_s,
  input logic              sclk_rise,
  input logic [WORD_W-1:0] shift_q,
  input logic [WORD_W-1:0] word,
  input logic              update_o
);
  a_r1_reset_clear: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (word == '0 && !update_o && shift_q == '0));

  a_r2_one_bit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_rise |=> shift_q == {$past(shift_q[WORD_W-2:0]), $past(sdata_s)});

  a_r9_no_step_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_rise |=> $stable(shift_q));

  a_r6_follow_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sload_s |=> word == $past(shift_q));

  a_r7_hold_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sload_s |=> $stable(word));

  a_r8_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |=> !update_o);

  a_r8_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> (!$past(sload_s) && $past(sload_s, 2)));
endmodule

bind cfg_serial_rx cfg_serial_rx_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sload_s   (sload_s),
  .sdata_s   (sdata_s),
  .sclk_rise (sclk_rise),
  .shift_q   (shift_w),
  .word      ({pre_div_o, post_div_o, fb_div_o}),
  .update_o  (update_o)
);

// File: tb/cfg_serial_rx_test.sv
module cfg_serial_rx_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, sload = 1'b0;
  logic [4:0] pre_div;
  logic [2:0] post_div;
  logic [9:0] fb_div;
  logic       update;

  int checks = 0, errors = 0, upd_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_serial_rx uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata), .sload_i(sload),
    .pre_div_o(pre_div), .post_div_o(post_div), .fb_div_o(fb_div), .update_o(update)
  );

  // pin-level reference model: history of sampled pin triples
  typedef struct packed {logic sc; logic sd; logic sl;} pin_t;
  pin_t        hist[$];
  logic [17:0] m_shift = '0, m_word = '0;
  logic        m_upd = 1'b0;

  initial repeat (4) hist.push_back('0);

  always @(posedge clk or negedge rst_n) begin : model
    pin_t cur, old;
    if (!rst_n) begin
      m_shift = '0; m_word = '0; m_upd = 1'b0;
      hist.delete();
      repeat (4) hist.push_back('0);
    end else begin
      hist.push_back('{sclk, sdata, sload});
      void'(hist.pop_front());
      cur = hist[1];
      old = hist[0];
      m_upd = old.sl && !cur.sl;
      if (cur.sl) m_word = m_shift;
      if (cur.sc && !old.sc) m_shift = {m_shift[16:0], cur.sd};
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] outw();
    return {pre_div, post_div, fb_div};
  endfunction

  always @(negedge clk) begin
    #1;
    chk("R10 model", {outw(), update}, {m_word, m_upd});
    if (update) upd_cnt++;
  end

  task automatic drive(logic sc, logic sd, logic sl);
    @(negedge clk);
    sclk = sc; sdata = sd; sload = sl;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_bits(logic [31:0] v, int n, logic sl);
    for (int i = n - 1; i >= 0; i--) begin
      drive(1'b0, v[i], sl);
      drive(1'b1, v[i], sl);
    end
    drive(1'b0, 1'b0, sl);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_load();
    drive(1'b0, 1'b0, 1'b1);
    drive(1'b0, 1'b0, 1'b1);
    drive(1'b0, 1'b0, 1'b0);
    settle();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
    end
  end

  initial begin : main
    logic [17:0] wa, wb, wc, wd, exp_w;
    int base;
    wa = {5'h15, 3'h5, 10'h2a3};
    wb = {5'h0a, 3'h2, 10'h15c};
    wc = {5'h1f, 3'h0, 10'h3c1};
    wd = {5'h03, 3'h6, 10'h0f0};

    repeat (5) @(negedge clk);
    #1;
    chk("R1 reset word", outw(), 18'h0);
    chk("R1 reset update", update, 0);
    rst_n = 1'b1;

    // R3 / R2: full word, field positions
    base = upd_cnt;
    send_bits(wa, 18, 1'b0);
    do_load();
    chk("R3 pre field", pre_div, 5'h15);
    chk("R3 post field", post_div, 3'h5);
    chk("R3 fb field", fb_div, 10'h2a3);
    chk("R2 word", outw(), wa);
    chk("R8 one pulse per fall", upd_cnt - base, 1);

    // R7: shift without load keeps outputs
    send_bits(wb, 18, 1'b0);
    settle();
    chk("R7 hold after shifting", outw(), wa);

    // R10 / R5: exact transfer latency after strobe rise
    @(negedge clk); sload = 1'b1;
    @(negedge clk);
    @(negedge clk); #2;
    chk("R10 before third edge", outw(), wa);
    @(negedge clk); #2;
    chk("R5 transfer on rise", outw(), wb);
    sload = 1'b0;
    settle();

    // R4: short stream shifts older bits up
    send_bits(32'b10110, 5, 1'b0);
    do_load();
    exp_w = {wb[12:0], 5'b10110};
    chk("R4 short stream", outw(), exp_w);

    // R4: overlong stream keeps last 18
    send_bits({2'b11, wc}, 20, 1'b0);
    do_load();
    chk("R4 overlong stream", outw(), wc);

    // R9: data toggles with no clock rise
    for (int i = 0; i < 6; i++) drive(1'b0, i[0], 1'b0);
    drive(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) drive(1'b1, i[0], 1'b0);
    drive(1'b0, 1'b0, 1'b0);
    do_load();
    exp_w = {wc[16:0], 1'b1};
    chk("R9 data glitches ignored", outw(), exp_w);

    // R6: transparency while strobe held high
    base = upd_cnt;
    drive(1'b0, 1'b0, 1'b1);
    settle();
    send_bits({23'h0, wd[17:9]}, 9, 1'b1);
    settle();
    chk("R6 follows mid-word", outw(), {exp_w[8:0], wd[17:9]});
    send_bits({23'h0, wd[8:0]}, 9, 1'b1);
    settle();
    chk("R6 follows full word", outw(), wd);
    chk("R8 no pulse while high", upd_cnt - base, 0);
    drive(1'b0, 1'b0, 1'b0);
    settle();
    chk("R8 pulse on fall", upd_cnt - base, 1);
    send_bits(18'h3ffff, 18, 1'b0);
    settle();
    chk("R7 frozen after fall", outw(), wd);

    // boundary values
    do_load();
    chk("R3 all ones", outw(), 18'h3ffff);
    send_bits(18'h0, 18, 1'b0);
    do_load();
    chk("R3 all zeros", outw(), 18'h0);

    // R1: reset mid-operation
    send_bits(wa, 18, 1'b0);
    do_load();
    @(negedge clk); rst_n = 1'b0;
    #2;
    chk("R1 async clear", {outw(), update}, 19'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    do_load();
    chk("R1 shift cleared", outw(), 18'h0);

    done = 1;
    summary();
  end
endmodule